// File: doc/BRIEF.md
# Speculative Path History Queue

This block holds the ordered list of in-flight and recently retired indirect branches for one hardware thread. Each record carries the branch PC, its target and a sequence number. New branches go in at the tail as they are predicted. A pipeline flush removes every record younger than the flush point. Retirement either advances a head marker or drops the oldest record. When a branch resolves, its target can be corrected in place.

Downstream hashing logic reads a small window of the most recent targets, youngest first, together with the youngest record's PC. Every operation takes one clock, and at most one operation is accepted in a cycle. All outputs are combinational views of the registered state, so an operation is visible on the ports right after the clock edge that accepts it.

Top module: `path_hist_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `occupancy`=0, `head_mark`=0, `full`=0, `overflow`=0, every `path_vld` bit 0 and every `path_tgt` slot 0.
- R2: A record operation on a queue that is not full appends {PC, target, sequence} at the tail, so `occupancy` rises by one and the new target appears in path slot 0 after the accepting edge.
- R3: `full` is 1 exactly when `occupancy` equals DEPTH. A record while full is dropped: the contents stay as they were, and `overflow` is 1 for the single cycle after that edge.
- R4: A squash with value S finds the oldest record whose sequence number is greater than S (unsigned compare) and removes it and every younger record, even younger ones whose number is not above S. If no record is above S, nothing changes. `head_mark` is not altered by a squash.
- R5: A commit with value S has no effect unless `head_mark` < `occupancy` and the record at age position `head_mark` (0 = oldest) has sequence number ≤ S. This covers an empty queue.
- R6: An accepted commit with `head_mark` < PATH_LEN increments `head_mark` and leaves the records untouched.
- R7: An accepted commit with `head_mark` ≥ PATH_LEN drops the oldest record, so `occupancy` falls by one while `head_mark` stays the same.
- R8: A resolve overwrites the target of the youngest record only. A resolve on an empty queue has no effect.
- R9: Path slot p, at bits [p*PC_W +: PC_W] of `path_tgt`, holds the target of the p-th youngest record (slot 0 = youngest). `path_vld[p]` is 1 iff p < `occupancy`, and an invalid slot reads 0. `young_pc` is the youngest record's PC, or 0 when the queue is empty.
- R10: When several operation requests arrive in one cycle, only the highest-priority one acts, in the order squash, resolve, commit, record. The others are ignored.
- R11: Storage is circular, so after oldest-record drops the queue still fills to DEPTH and reports targets in correct order across the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record request |
| rec_pc | input | PC_W | PC of the branch to record |
| rec_tgt | input | PC_W | Predicted target of the branch |
| rec_seq | input | SEQ_W | Sequence number of the branch |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Records numbered above this are removed |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Sequence number being retired |
| resolve_valid | input | 1 | Target correction request |
| resolve_tgt | input | PC_W | Corrected target for the youngest record |
| path_tgt | output | PATH_LEN*PC_W | Recent targets, slot 0 youngest |
| path_vld | output | PATH_LEN | Per-slot valid |
| young_pc | output | PC_W | PC of the youngest record |
| occupancy | output | $clog2(DEPTH)+1 | Number of stored records |
| head_mark | output | $clog2(PATH_LEN+1) | Committed-history marker |
| full | output | 1 | Queue holds DEPTH records |
| overflow | output | 1 | A record was dropped on the previous edge |

## Verification
A wrong read pointer or count shows up on the path window the cycle after the operation: targets appear shifted, out of order or with the wrong valid bits. A bad truncation point in a squash changes `occupancy` and the youngest target at once. A marker that steps wrongly shows on `head_mark`, and after that in which commit is the first to start shrinking the queue. The bench keeps a queue model in step with the operations and compares every visible output after each operation. Wrap errors surface only after oldest-record drops, so one scenario pops and then refills past the array end.

// File: rtl/phq_pkg.sv
package phq_pkg;

    parameter int PC_W  = 16;
    parameter int SEQ_W = 8;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  tgt;
        logic [SEQ_W-1:0] seq;
    } phq_rec_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SQUASH,
        OP_RESOLVE,
        OP_COMMIT,
        OP_RECORD
    } phq_op_e;

    // One operation per cycle, fixed priority
    function automatic phq_op_e pick_op(input logic sq, input logic rs,
                                        input logic cm, input logic rc);
        if (sq)      return OP_SQUASH;
        else if (rs) return OP_RESOLVE;
        else if (cm) return OP_COMMIT;
        else if (rc) return OP_RECORD;
        else         return OP_NONE;
    endfunction

endpackage

// File: rtl/phq_store.sv
module phq_store
    import phq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [PTR_W-1:0]                  wr_idx,
    input  phq_rec_t                          wr_rec,
    input  logic                              tw_en,
    input  logic [PTR_W-1:0]                  tw_idx,
    input  logic [PC_W-1:0]                   tw_tgt,
    output logic [DEPTH-1:0][PC_W-1:0]        pc_o,
    output logic [DEPTH-1:0][PC_W-1:0]        tgt_o,
    output logic [DEPTH-1:0][SEQ_W-1:0]       seq_o
);

    phq_rec_t mem [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[s] <= '0;
            end else if (wr_en && wr_idx == PTR_W'(s)) begin
                mem[s] <= wr_rec;
            end else if (tw_en && tw_idx == PTR_W'(s)) begin
                mem[s].tgt <= tw_tgt;
            end
        end
        assign pc_o[s]  = mem[s].pc;
        assign tgt_o[s] = mem[s].tgt;
        assign seq_o[s] = mem[s].seq;
    end

endmodule

// File: rtl/phq_squash_find.sv
module phq_squash_find
    import phq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
    input  logic [PTR_W-1:0]            rd_ptr,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [SEQ_W-1:0]            lim,
    output logic [CNT_W-1:0]            keep_cnt
);

    logic [DEPTH-1:0] younger;

    // younger[i]: record at age i (0 = oldest) is live and above the limit
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        logic [PTR_W-1:0] slot;
        assign slot       = rd_ptr + PTR_W'(i);
        assign younger[i] = (CNT_W'(i) < cnt) && (seq_i[slot] > lim);
    end

    // Oldest flagged age wins; none flagged keeps everything
    always_comb begin
        keep_cnt = cnt;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (younger[i]) keep_cnt = CNT_W'(i);
        end
    end

endmodule

// File: rtl/phq_path_view.sv
module phq_path_view
    import phq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int PATH_LEN = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic [DEPTH-1:0][PC_W-1:0] pc_i,
    input  logic [DEPTH-1:0][PC_W-1:0] tgt_i,
    input  logic [PTR_W-1:0]           rd_ptr,
    input  logic [CNT_W-1:0]           cnt,
    output logic [PATH_LEN*PC_W-1:0]   path_tgt,
    output logic [PATH_LEN-1:0]        path_vld,
    output logic [PC_W-1:0]            young_pc
);

    logic [PTR_W-1:0] young_slot;
    assign young_slot = rd_ptr + PTR_W'(cnt) - PTR_W'(1);
    assign young_pc   = (cnt != '0) ? pc_i[young_slot] : '0;

    for (genvar p = 0; p < PATH_LEN; p++) begin : g_path
        logic [PTR_W-1:0] slot;
        assign slot        = rd_ptr + PTR_W'(cnt) - PTR_W'(p + 1);
        assign path_vld[p] = (int'(cnt) > p);
        assign path_tgt[p*PC_W +: PC_W] = path_vld[p] ? tgt_i[slot] : '0;
    end

endmodule

// File: rtl/path_hist_queue.sv
module path_hist_queue
    import phq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int PATH_LEN = 3,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1,
    localparam int MARK_W = $clog2(PATH_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rec_valid,
    input  logic [PC_W-1:0]          rec_pc,
    input  logic [PC_W-1:0]          rec_tgt,
    input  logic [SEQ_W-1:0]         rec_seq,
    input  logic                     squash_valid,
    input  logic [SEQ_W-1:0]         squash_seq,
    input  logic                     commit_valid,
    input  logic [SEQ_W-1:0]         commit_seq,
    input  logic                     resolve_valid,
    input  logic [PC_W-1:0]          resolve_tgt,
    output logic [PATH_LEN*PC_W-1:0] path_tgt,
    output logic [PATH_LEN-1:0]      path_vld,
    output logic [PC_W-1:0]          young_pc,
    output logic [CNT_W-1:0]         occupancy,
    output logic [MARK_W-1:0]        head_mark,
    output logic                     full,
    output logic                     overflow
);

    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic [MARK_W-1:0] hmark;
    logic              ovf_q;

    logic [DEPTH-1:0][PC_W-1:0]  pc_arr;
    logic [DEPTH-1:0][PC_W-1:0]  tgt_arr;
    logic [DEPTH-1:0][SEQ_W-1:0] seq_arr;
    logic [CNT_W-1:0]            keep_cnt;

    phq_op_e    op;
    phq_rec_t   new_rec;
    logic [PTR_W-1:0] tail_slot, young_slot, mark_slot;
    logic       commit_ok, mark_at_limit, do_write, do_fix;

    assign op         = pick_op(squash_valid, resolve_valid, commit_valid, rec_valid);
    assign full       = (cnt == CNT_W'(DEPTH));
    assign tail_slot  = rd_ptr + PTR_W'(cnt);
    assign young_slot = rd_ptr + PTR_W'(cnt) - PTR_W'(1);
    assign mark_slot  = rd_ptr + PTR_W'(hmark);

    assign commit_ok     = (int'(hmark) < int'(cnt)) && (seq_arr[mark_slot] <= commit_seq);
    assign mark_at_limit = (int'(hmark) >= PATH_LEN);

    assign new_rec  = '{pc: rec_pc, tgt: rec_tgt, seq: rec_seq};
    assign do_write = (op == OP_RECORD) && !full;
    assign do_fix   = (op == OP_RESOLVE) && (cnt != '0);

    phq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (do_write),
        .wr_idx (tail_slot),
        .wr_rec (new_rec),
        .tw_en  (do_fix),
        .tw_idx (young_slot),
        .tw_tgt (resolve_tgt),
        .pc_o   (pc_arr),
        .tgt_o  (tgt_arr),
        .seq_o  (seq_arr)
    );

    phq_squash_find #(.DEPTH(DEPTH)) u_find (
        .seq_i    (seq_arr),
        .rd_ptr   (rd_ptr),
        .cnt      (cnt),
        .lim      (squash_seq),
        .keep_cnt (keep_cnt)
    );

    phq_path_view #(.DEPTH(DEPTH), .PATH_LEN(PATH_LEN)) u_view (
        .pc_i     (pc_arr),
        .tgt_i    (tgt_arr),
        .rd_ptr   (rd_ptr),
        .cnt      (cnt),
        .path_tgt (path_tgt),
        .path_vld (path_vld),
        .young_pc (young_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            cnt    <= '0;
            hmark  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            case (op)
                OP_SQUASH: cnt <= keep_cnt;
                OP_COMMIT: begin
                    if (commit_ok) begin
                        if (mark_at_limit) begin
                            rd_ptr <= rd_ptr + PTR_W'(1);
                            cnt    <= cnt - CNT_W'(1);
                        end else begin
                            hmark  <= hmark + MARK_W'(1);
                        end
                    end
                end
                OP_RECORD: begin
                    if (full) ovf_q <= 1'b1;
                    else      cnt   <= cnt + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign occupancy = cnt;
    assign head_mark = hmark;
    assign overflow  = ovf_q;

    // ---------------- assertions ----------------
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DEPTH);

    assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !squash_valid && !resolve_valid && !commit_valid && full)
        |=> (overflow && $stable(occupancy)));

    assert_squash_no_grow_R4: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> (occupancy <= $past(occupancy)) && $stable(head_mark));

    assert_commit_step_R7: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && !squash_valid && !resolve_valid)
        |=> ($stable(occupancy) ||
             ((occupancy + CNT_W'(1) == $past(occupancy)) && $stable(head_mark))));

    assert_mark_limit_R6: assert property (@(posedge clk) disable iff (rst)
        int'(head_mark) <= PATH_LEN);

    assert_resolve_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
        (resolve_valid && !squash_valid) |=> $stable(occupancy));

endmodule

// File: tb/path_hist_queue_bench.sv
`timescale 1ns/1ps
module path_hist_queue_bench;
    localparam int DEPTH = 8;
    localparam int PL    = 3;
    localparam int PW    = 16;
    localparam int SW    = 8;

    logic clk = 1'b0;
    logic rst;
    logic rec_valid, squash_valid, commit_valid, resolve_valid;
    logic [PW-1:0] rec_pc, rec_tgt, resolve_tgt;
    logic [SW-1:0] rec_seq, squash_seq, commit_seq;
    logic [PL*PW-1:0] path_tgt;
    logic [PL-1:0] path_vld;
    logic [PW-1:0] young_pc;
    logic [3:0] occupancy;
    logic [1:0] head_mark;
    logic full, overflow;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [PW-1:0] m_pc[$];
    logic [PW-1:0] m_tgt[$];
    logic [SW-1:0] m_seq[$];
    int m_mark;

    always #10 clk = ~clk;

    path_hist_queue u_path_hist_queue (
        .clk(clk), .rst(rst),
        .rec_valid(rec_valid), .rec_pc(rec_pc), .rec_tgt(rec_tgt), .rec_seq(rec_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .resolve_valid(resolve_valid), .resolve_tgt(resolve_tgt),
        .path_tgt(path_tgt), .path_vld(path_vld), .young_pc(young_pc),
        .occupancy(occupancy), .head_mark(head_mark),
        .full(full), .overflow(overflow)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rec_valid = 0; squash_valid = 0; commit_valid = 0; resolve_valid = 0;
        rec_pc = 0; rec_tgt = 0; rec_seq = 0; squash_seq = 0; commit_seq = 0; resolve_tgt = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst = 1; idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_pc.delete(); m_tgt.delete(); m_seq.delete(); m_mark = 0;
    endtask

    // model updates, from the requirements
    function automatic void m_record(input logic [PW-1:0] pc, input logic [PW-1:0] t, input logic [SW-1:0] s);
        if (m_tgt.size() < DEPTH) begin
            m_pc.push_back(pc); m_tgt.push_back(t); m_seq.push_back(s);
        end
    endfunction

    function automatic void m_squash(input logic [SW-1:0] s);
        int n = m_seq.size();
        int cut = n;
        for (int i = n - 1; i >= 0; i--) if (m_seq[i] > s) cut = i;
        while (m_seq.size() > cut) begin
            void'(m_pc.pop_back()); void'(m_tgt.pop_back()); void'(m_seq.pop_back());
        end
    endfunction

    function automatic void m_commit(input logic [SW-1:0] s);
        if (m_mark < m_seq.size() && m_seq[m_mark] <= s) begin
            if (m_mark >= PL) begin
                void'(m_pc.pop_front()); void'(m_tgt.pop_front()); void'(m_seq.pop_front());
            end else m_mark++;
        end
    endfunction

    function automatic void m_resolve(input logic [PW-1:0] t);
        if (m_tgt.size() > 0) m_tgt[m_tgt.size()-1] = t;
    endfunction

    task automatic op_record(input logic [PW-1:0] pc, input logic [PW-1:0] t, input logic [SW-1:0] s);
        rec_valid = 1; rec_pc = pc; rec_tgt = t; rec_seq = s;
        m_record(pc, t, s);
        step();
    endtask

    task automatic op_squash(input logic [SW-1:0] s);
        squash_valid = 1; squash_seq = s; m_squash(s); step();
    endtask

    task automatic op_commit(input logic [SW-1:0] s);
        commit_valid = 1; commit_seq = s; m_commit(s); step();
    endtask

    task automatic op_resolve(input logic [PW-1:0] t);
        resolve_valid = 1; resolve_tgt = t; m_resolve(t); step();
    endtask

    task automatic check_state(input string tag);
        int n = m_tgt.size();
        chk(tag, "occupancy", int'(occupancy), n);
        chk(tag, "head_mark", int'(head_mark), m_mark);
        chk(tag, "full", int'(full), (n == DEPTH) ? 1 : 0);
        chk(tag, "young_pc", int'(young_pc), (n > 0) ? int'(m_pc[n-1]) : 0);
        for (int p = 0; p < PL; p++) begin
            chk(tag, $sformatf("path_vld[%0d]", p), int'(path_vld[p]), (p < n) ? 1 : 0);
            chk(tag, $sformatf("path_tgt[%0d]", p), int'(path_tgt[p*PW +: PW]),
                (p < n) ? int'(m_tgt[n-1-p]) : 0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check_state("R1");
        chk("R1", "overflow", int'(overflow), 0);
    endtask

    task automatic t_record();
        do_reset();
        op_record(16'h0100, 16'h1000, 8'd10);
        check_state("R2");
        for (int i = 1; i < 4; i++) op_record(16'h0100 + 16'(i), 16'h1000 + 16'(i), 8'(10 + 10*i));
        check_state("R9");
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < DEPTH; i++) op_record(16'h0200 + 16'(i), 16'h2000 + 16'(i), 8'(i + 1));
        check_state("R3");
        chk("R3", "overflow before drop", int'(overflow), 0);
        op_record(16'h02FF, 16'h2FFF, 8'd99);
        chk("R3", "overflow after drop", int'(overflow), 1);
        check_state("R3");
        step();
        chk("R3", "overflow one cycle", int'(overflow), 0);
    endtask

    task automatic t_squash();
        do_reset();
        for (int i = 1; i <= 5; i++) op_record(16'h0300 + 16'(i), 16'h3000 + 16'(i), 8'(5*i));
        op_squash(8'd12);
        check_state("R4");
        op_squash(8'd30);
        check_state("R4");
        op_squash(8'd0);
        check_state("R4");
        op_record(16'h0311, 16'h3111, 8'd5);
        op_record(16'h0312, 16'h3112, 8'd40);
        op_record(16'h0313, 16'h3113, 8'd8);
        op_squash(8'd10);
        check_state("R4");
    endtask

    task automatic t_commit();
        do_reset();
        op_commit(8'd99);
        check_state("R5");
        for (int i = 1; i <= 5; i++) op_record(16'h0400 + 16'(i), 16'h4000 + 16'(i), 8'(i));
        op_commit(8'd0);
        check_state("R5");
        op_commit(8'd1);
        check_state("R6");
        op_commit(8'd1);
        check_state("R5");
        op_commit(8'd5);
        op_commit(8'd5);
        check_state("R6");
        op_commit(8'd5);
        check_state("R7");
        op_commit(8'd5);
        check_state("R7");
        op_commit(8'd5);
        check_state("R5");
        for (int i = 6; i <= 12; i++) op_record(16'h0400 + 16'(i), 16'h4000 + 16'(i), 8'(i));
        check_state("R11");
        op_squash(8'd9);
        check_state("R11");
    endtask

    task automatic t_resolve();
        do_reset();
        op_resolve(16'hDEAD);
        check_state("R8");
        op_record(16'h0501, 16'h5001, 8'd1);
        op_record(16'h0502, 16'h5002, 8'd2);
        op_resolve(16'hBEEF);
        check_state("R8");
    endtask

    task automatic t_priority();
        do_reset();
        for (int i = 1; i <= 3; i++) op_record(16'h0600 + 16'(i), 16'h6000 + 16'(i), 8'(i));
        squash_valid = 1; squash_seq = 8'd1; rec_valid = 1; rec_tgt = 16'h6FFF; rec_seq = 8'd9;
        m_squash(8'd1); step();
        check_state("R10");
        resolve_valid = 1; resolve_tgt = 16'h6AAA; commit_valid = 1; commit_seq = 8'd9;
        m_resolve(16'h6AAA); step();
        check_state("R10");
        commit_valid = 1; commit_seq = 8'd9; rec_valid = 1; rec_tgt = 16'h6BBB; rec_seq = 8'd4;
        m_commit(8'd9); step();
        check_state("R10");
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        t_reset();
        t_record();
        t_overflow();
        t_squash();
        t_commit();
        t_resolve();
        t_priority();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule